// File: doc/BRIEF.md
# Shared Peripheral Bus Arbiter

This block shares one synchronous peripheral bus among five requesters: a configuration unit and four CPU ports. Each requester presents a request, a read/write flag, a 16-bit address and 32-bit write data. When the bus is idle, the arbiter picks one winner. It then drives the winner's address, write data and direction onto a single shared bus for a programmable number of cycles.

The bus has no tri-states. Every peripheral drives its read data onto its own lane, and a peripheral that is not selected drives zero. The arbiter ORs all the lanes together. In the last cycle of the access it returns the result, together with a one-cycle done pulse, to the winner.

Priority has two levels. Any pending read beats any pending write. Within the same access type, the configuration unit wins over the CPUs, and a lower CPU index wins over a higher one. A grant, once given, runs to completion. A requester keeps its request asserted until it sees its done pulse.

Top module: `pbus_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `bus_valid_o` is 0 and `done_o` is 0. Reset asserted in the middle of an access ends that access at once.
- R2: When the bus is idle and both read requests (wr bit 0) and write requests (wr bit 1) are pending, a read requester is granted.
- R3: Among pending requests of the winning access type, requester index 0 (the configuration unit) is granted ahead of indices 1..4 (CPU0..CPU3).
- R4: Among CPU requests of the same access type, the lowest index is granted.
- R5: An access keeps `bus_valid_o` high for exactly `wait_cfg_i`+1 consecutive cycles. The value used is the one sampled in the idle cycle when the request is accepted, and later changes to `wait_cfg_i` do not affect a running access.
- R6: While `bus_valid_o` is high, `bus_addr_o`, `bus_wdata_o` and `bus_wr_o` equal the granted requester's address, write data and flag, and stay stable.
- R7: In the last access cycle, `rdata_o` equals the OR of all `pdev_rdata_i` lanes for a read and is 0 for a write. It is 0 in every other cycle.
- R8: A request that arrives during an access, at any priority, does not change the grant until that access completes.
- R9: `done_o` is at most one-hot. It is high only for the granted requester, only in the last access cycle, and it is followed by at least one idle cycle before the next access.
- R10: While `bus_valid_o` is low, `bus_addr_o`, `bus_wdata_o` and `bus_wr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | 5 | Request per requester (bit 0 configuration unit, bits 1..4 CPU0..CPU3) |
| wr_i | input | 5 | Per-requester direction, 1 = write, 0 = read |
| addr_i | input | 80 | Per-requester 16-bit addresses, requester k at bits 16k+15:16k |
| wdata_i | input | 160 | Per-requester 32-bit write data, requester k at bits 32k+31:32k |
| wait_cfg_i | input | 4 | Programmed wait count; each access lasts this value plus one cycle |
| pdev_rdata_i | input | 128 | Read data lanes of four peripherals, zero when not selected |
| bus_valid_o | output | 1 | Shared bus access in progress |
| bus_wr_o | output | 1 | Shared bus direction |
| bus_addr_o | output | 16 | Shared bus address |
| bus_wdata_o | output | 32 | Shared bus write data |
| done_o | output | 5 | One-cycle completion pulse to the granted requester |
| rdata_o | output | 32 | Read data returned with done |

## Verification
A corrupted grant register shows up within the first bus cycle, as the wrong address on `bus_addr_o`, and later as a done pulse at the wrong index. A faulty wait counter shows up at the end of the access, as a `bus_valid_o` window that is too short or too long, or as a missing done pulse. Errors in the priority picker appear in the first cycle after a contested idle cycle. Errors in the read-data gathering appear only in the done cycle of a read, as a value that differs from the OR of the lanes.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int unsigned PBUS_AW = 16;
  localparam int unsigned PBUS_DW = 32;
  localparam int unsigned PBUS_WW = 4;
  localparam int unsigned PBUS_CFG_IDX = 0;
endpackage

// File: rtl/pbus_pick.sv
module pbus_pick #(
  parameter int unsigned NREQ = 5
) (
  input  logic [NREQ-1:0] req_i,
  input  logic [NREQ-1:0] wr_i,
  output logic [NREQ-1:0] gnt_o
);
  logic [NREQ-1:0] rd_pend;
  logic [NREQ-1:0] cls;

  always_comb begin
    rd_pend = req_i & ~wr_i;
    cls     = (|rd_pend) ? rd_pend : req_i;
    gnt_o   = cls & (~cls + NREQ'(1));
  end
endmodule

// File: rtl/pbus_rd_or.sv
module pbus_rd_or #(
  parameter int unsigned NDEV = 4,
  parameter int unsigned DW   = 32
) (
  input  logic [NDEV*DW-1:0] lanes_i,
  output logic [DW-1:0]      or_o
);
  logic [DW-1:0] acc [NDEV+1];

  assign acc[0] = '0;
  for (genvar d = 0; d < NDEV; d++) begin : g_lane
    assign acc[d+1] = acc[d] | lanes_i[d*DW +: DW];
  end
  assign or_o = acc[NDEV];
endmodule

// File: rtl/pbus_wait_timer.sv
module pbus_wait_timer #(
  parameter int unsigned WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [WW-1:0] load_i,
  output logic          busy_o,
  output logic          last_o
);
  logic          busy_q, busy_d;
  logic [WW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = load_i;
    end else if (busy_q && (cnt_q == '0)) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - WW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == '0);

  assert_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - WW'(1)))
    else $error("countdown broken");

  assert_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == '0 && !start_i) |=> !busy_q)
    else $error("access overran");
endmodule

// File: rtl/pbus_arbiter.sv
module pbus_arbiter #(
  parameter int unsigned NCPU = 4,
  parameter int unsigned AW   = pbus_pkg::PBUS_AW,
  parameter int unsigned DW   = pbus_pkg::PBUS_DW,
  parameter int unsigned NDEV = 4,
  parameter int unsigned WW   = pbus_pkg::PBUS_WW,
  localparam int unsigned NREQ = NCPU + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREQ-1:0]    req_i,
  input  logic [NREQ-1:0]    wr_i,
  input  logic [NREQ*AW-1:0] addr_i,
  input  logic [NREQ*DW-1:0] wdata_i,
  input  logic [WW-1:0]      wait_cfg_i,
  input  logic [NDEV*DW-1:0] pdev_rdata_i,
  output logic               bus_valid_o,
  output logic               bus_wr_o,
  output logic [AW-1:0]      bus_addr_o,
  output logic [DW-1:0]      bus_wdata_o,
  output logic [NREQ-1:0]    done_o,
  output logic [DW-1:0]      rdata_o
);
  logic [NREQ-1:0] pick;
  logic            busy, last, start;
  logic [DW-1:0]   rd_or;
  logic [NREQ-1:0] gnt_q, gnt_d;
  logic            wr_q, wr_d;
  logic [AW-1:0]   addr_q, addr_d, sel_addr;
  logic [DW-1:0]   wdata_q, wdata_d, sel_wdata;

  pbus_pick #(.NREQ(NREQ)) u_pick (
    .req_i (req_i),
    .wr_i  (wr_i),
    .gnt_o (pick)
  );

  pbus_wait_timer #(.WW(WW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .load_i  (wait_cfg_i),
    .busy_o  (busy),
    .last_o  (last)
  );

  pbus_rd_or #(.NDEV(NDEV), .DW(DW)) u_rd_or (
    .lanes_i (pdev_rdata_i),
    .or_o    (rd_or)
  );

  assign start = !busy && (|req_i);

  always_comb begin
    sel_addr  = '0;
    sel_wdata = '0;
    for (int k = 0; k < int'(NREQ); k++) begin
      sel_addr  = sel_addr  | (addr_i[k*AW +: AW]  & {AW{pick[k]}});
      sel_wdata = sel_wdata | (wdata_i[k*DW +: DW] & {DW{pick[k]}});
    end
  end

  always_comb begin
    gnt_d   = gnt_q;
    wr_d    = wr_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (start) begin
      gnt_d   = pick;
      wr_d    = |(pick & wr_i);
      addr_d  = sel_addr;
      wdata_d = sel_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      gnt_q   <= gnt_d;
      wr_q    <= wr_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  assign bus_valid_o = busy;
  assign bus_wr_o    = busy & wr_q;
  assign bus_addr_o  = addr_q  & {AW{busy}};
  assign bus_wdata_o = wdata_q & {DW{busy}};
  assign done_o      = gnt_q & {NREQ{last}};
  assign rdata_o     = rd_or & {DW{last & ~wr_q}};

  assert_pick_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> $onehot(pick))
    else $error("picker gave no single winner");

  assert_read_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && |(req_i & ~wr_i)) |-> |(pick & req_i & ~wr_i))
    else $error("write granted over read");

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> ($stable(bus_addr_o) && $stable(bus_wdata_o) && $stable(bus_wr_o)))
    else $error("bus changed mid access");

  assert_no_preempt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> $stable(gnt_q))
    else $error("grant preempted");

  assert_done_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_o))
    else $error("done not one-hot");

  assert_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_o) |=> !bus_valid_o)
    else $error("no idle cycle after done");

  assert_rdata_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|done_o) |-> (rdata_o == '0))
    else $error("read data outside done");
endmodule

// File: tb/pbus_arbiter_bench.sv
module pbus_arbiter_bench;
  localparam int NREQ = 5;
  localparam int NVEC = 8;
  // entry: {req[4:0], wr[4:0], wait[3:0], winner[2:0]}
  localparam logic [16:0] VEC [NVEC] = '{
    {5'b00001, 5'b00000, 4'd0,  3'd0},
    {5'b11110, 5'b00000, 4'd2,  3'd1},
    {5'b11111, 5'b00001, 4'd1,  3'd1},
    {5'b10001, 5'b00001, 4'd3,  3'd4},
    {5'b11111, 5'b11111, 4'd0,  3'd0},
    {5'b11100, 5'b01100, 4'd5,  3'd4},
    {5'b01010, 5'b01010, 4'd15, 3'd1},
    {5'b11111, 5'b01111, 4'd4,  3'd4}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NREQ-1:0]   req, wr;
  logic [NREQ*16-1:0] addr;
  logic [NREQ*32-1:0] wdata;
  logic [3:0]        wait_cfg;
  logic [127:0]      pdev;
  logic              bus_valid, bus_wr;
  logic [15:0]       bus_addr;
  logic [31:0]       bus_wdata;
  logic [NREQ-1:0]   done;
  logic [31:0]       rdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pbus_arbiter u_pbus_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .wait_cfg_i(wait_cfg), .pdev_rdata_i(pdev),
    .bus_valid_o(bus_valid), .bus_wr_o(bus_wr), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .done_o(done), .rdata_o(rdata)
  );

  function automatic logic [15:0] addr_of(int k);
    return 16'h1000 + 16'(k) * 16'h0111;
  endfunction
  function automatic logic [31:0] wdata_of(int k);
    return 32'hA5A0_0000 + 32'(k) * 32'h0001_0203;
  endfunction

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic set_pdev(input int seed, output logic [31:0] orv);
    orv = '0;
    for (int j = 0; j < 4; j++) begin
      pdev[j*32 +: 32] = (32'h1 << (j*8 + seed)) | (32'h0000_0100 * 32'(seed));
      orv = orv | pdev[j*32 +: 32];
    end
  endtask

  // walks negedges until done; counts bus_valid cycles and checks the bus contents
  task automatic run_to_done(input int win, input bit is_wr, input string rq,
                             output int cycles, output logic [4:0] dn, output logic [31:0] rd);
    bit addr_ok = 1'b1;
    cycles = 0; dn = '0; rd = '0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (bus_valid) begin
        cycles++;
        if (bus_addr != addr_of(win) || bus_wdata != wdata_of(win) || bus_wr != is_wr)
          addr_ok = 1'b0;
      end
      if (|done) begin
        dn = done; rd = rdata;
        break;
      end
    end
    check(addr_ok, {rq, " R6 bus contents"}, 32'(bus_addr), 32'(addr_of(win)));
  endtask

  initial begin : watchdog
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    logic [4:0] dn;
    logic [31:0] rd, orv;
    rst_n = 1'b0; req = '0; wr = '0; wait_cfg = '0; pdev = '0;
    for (int k = 0; k < NREQ; k++) begin
      addr[k*16 +: 16]  = addr_of(k);
      wdata[k*32 +: 32] = wdata_of(k);
    end
    repeat (3) @(negedge clk);
    check(!bus_valid && done == '0, "R1 in reset", {31'b0, bus_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!bus_valid && done == '0, "R1 after reset", {27'b0, done}, 32'h0);
    check(bus_addr == '0 && bus_wdata == '0 && !bus_wr, "R10 idle bus zero", 32'(bus_addr), 32'h0);

    // table walk: R2 R3 R4 R5 R6 R7 R9
    for (int v = 0; v < NVEC; v++) begin
      int w; bit iw; logic [4:0] exp_dn;
      w  = int'(VEC[v][2:0]);
      iw = VEC[v][7 + w];
      exp_dn = 5'b1 << w;
      set_pdev(v, orv);
      req = VEC[v][16:12]; wr = VEC[v][11:7]; wait_cfg = VEC[v][6:3];
      run_to_done(w, iw, $sformatf("vec%0d", v), cyc, dn, rd);
      check(dn == exp_dn, "R2/R3/R4 grant winner (R2 R3 R4)", {27'b0, dn}, {27'b0, exp_dn});
      check(cyc == int'(VEC[v][6:3]) + 1, "R5 access length", 32'(cyc), 32'(int'(VEC[v][6:3]) + 1));
      check(rd == (iw ? 32'h0 : orv), "R7 read data", rd, iw ? 32'h0 : orv);
      req = '0;
      @(negedge clk);
      check(!bus_valid && done == '0 && bus_addr == '0, "R9 R10 idle after done", {31'b0, bus_valid}, 32'h0);
    end

    // R5: wait count changed mid access has no effect
    set_pdev(3, orv);
    req = 5'b00100; wr = '0; wait_cfg = 4'd3;
    @(negedge clk);
    check(bus_valid, "R5 started", {31'b0, bus_valid}, 32'h1);
    wait_cfg = 4'd0;
    run_to_done(2, 1'b0, "R5 midchange", cyc, dn, rd);
    check(cyc + 1 == 4, "R5 wait sampled at start", 32'(cyc + 1), 32'd4);
    req = '0;
    @(negedge clk);

    // R8: higher priority read arriving mid access does not preempt
    req = 5'b10000; wr = 5'b10000; wait_cfg = 4'd3;
    @(negedge clk);
    req = 5'b10001; wr = 5'b10000;
    run_to_done(4, 1'b1, "R8 running", cyc, dn, rd);
    check(dn == 5'b10000, "R8 no preemption", {27'b0, dn}, 32'h10);
    check(rd == 32'h0, "R7 write returns zero", rd, 32'h0);
    req = 5'b00001;
    @(negedge clk);
    check(!bus_valid, "R9 gap before next grant", {31'b0, bus_valid}, 32'h0);
    @(negedge clk);
    check(bus_valid && bus_addr == addr_of(0), "R3 config served next", 32'(bus_addr), 32'(addr_of(0)));
    run_to_done(0, 1'b0, "R8 follow", cyc, dn, rd);
    check(dn == 5'b00001, "R8 config done", {27'b0, dn}, 32'h1);
    req = '0;
    @(negedge clk);

    // R1: reset in the middle of an access
    req = 5'b00010; wr = 5'b00010; wait_cfg = 4'd8;
    repeat (3) @(negedge clk);
    check(bus_valid, "R1 access running", {31'b0, bus_valid}, 32'h1);
    rst_n = 1'b0; req = '0;
    #1;
    check(!bus_valid && done == '0, "R1 reset aborts", {31'b0, bus_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!bus_valid && bus_addr == '0, "R10 idle after reset", 32'(bus_addr), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule